// File: doc/BRIEF.md
# External Bus Mastership Handoff Controller

This block decides who drives the external memory bus: the chip or an outside master. The outside master pulls an active-low request line to ask for the bus. The block waits until no internal bus cycle is in progress. It then turns off the address, data, chip-select and strobe drivers, and only after that pulls the active-low acknowledge line low.

Taking the bus back uses both edges of the bus clock. The request line passes through a synchronizer clocked on falling edges, so a withdrawn request is detected on a falling edge. The control strobes are driven high (precharged) one and a half cycles later, on a rising edge. The external buffer enable turns off on the falling edge that follows. Address and data drivers come back on the next rising edge, and a one-cycle resume flag tells the internal bus logic at that edge that it may start cycles again.

Entry into sleep or standby and a manual reset are granted only while the chip owns the bus. In standby the acknowledge pin is not driven, and requests are ignored.

Top module: `bus_handoff_ctrl`

## Requirements
- R1: Reset puts the block in a reclaim sequence. During reset and in the first sampled cycle after it, ack_n=1, and addr_en, ctl_en, strobe_hi, ext_en and resume are all 0. The following cycles then show, in order: strobe_hi=1 with ctl_en=1; resume=1 with addr_en=ctl_en=1; ownership (addr_en=ctl_en=1, resume=0). This also holds when reset arrives while the bus is released.
- R2: A low on req_n passes through two falling-edge flops. It is acted on at the second rising edge after the first falling edge that samples it. At that edge addr_en and ctl_en drop to 0 while ack_n stays 1. On the falling edge that follows, ext_en rises to 1.
- R3: ack_n goes low one cycle after the drivers are turned off. Whenever ack_n=0, addr_en=0, ctl_en=0 and ext_en=1.
- R4: While cycle_busy=1 the bus is not released. Release starts at the first rising edge at which cycle_busy=0 and the synchronized request is active.
- R5: After a withdrawn request (req_n=1) is detected on a falling edge, ack_n returns high at the next rising edge. One rising edge after that (1.5 cycles after detection), strobe_hi=1 and ctl_en=1, with addr_en still 0.
- R6: ext_en falls to 0 on the first falling edge after strobe_hi rises. It is still 1 between that rising edge and that falling edge.
- R7: One rising edge after strobe_hi rises, addr_en=1 and resume=1 for exactly one cycle. After that the block owns the bus with resume=0.
- R8: sleep_go=sleep_req and mreset_go=mreset_req only while the bus is owned (addr_en=1, resume=0). At all other times both are 0.
- R9: While standby=1, ack_oe=0 and a low on req_n is ignored: the block stays owning the bus. With standby=0, ack_oe=1.
- R10: If req_n is low for only one cycle, ack_n still goes low for exactly one cycle. addr_en and ctl_en stay 0 during that cycle, and the block then goes through the reclaim sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Active-low bus request from the external master (asynchronous) |
| standby | input | 1 | Standby mode is active |
| cycle_busy | input | 1 | An internal bus cycle is in progress |
| sleep_req | input | 1 | Pending sleep/standby entry |
| mreset_req | input | 1 | Pending manual reset |
| ack_n | output | 1 | Active-low bus grant to the external master |
| ack_oe | output | 1 | Output enable of the acknowledge pin |
| addr_en | output | 1 | Address and data driver enable |
| ctl_en | output | 1 | Chip-select and strobe driver enable |
| strobe_hi | output | 1 | Strobes are forced to their inactive high level |
| ext_en | output | 1 | External buffer enable, held while the outside master may drive |
| resume | output | 1 | One-cycle flag: internal bus cycles may start |
| sleep_go | output | 1 | Sleep/standby entry granted |
| mreset_go | output | 1 | Manual reset granted |

## Verification
The release and reclaim path is driven by four request patterns, each of which tests a different mechanism:
- A request held over many cycles measures the synchronizer latency and the exact reclaim cycles.
- A request held while a bus cycle is still busy shows that the release is deferred, not dropped.
- A one-cycle request pulse shows the single-cycle acknowledge and that the drivers stay off during it.
- A request made during standby shows that the request is ignored and that the acknowledge pin is released.

Sleep and manual reset requests are raised both during a release and while the bus is owned, which separates held-off requests from granted ones. A mid-cycle sample, taken between a rising and a falling edge, separates the falling-edge buffer enable from the rising-edge strobe precharge. A reset during a release confirms that reset starts the reclaim sequence.

// File: rtl/bho_pkg.sv
package bho_pkg;

    typedef enum logic [5:0] {
        ST_OWNED     = 6'b000001,
        ST_RELEASING = 6'b000010,
        ST_RELEASED  = 6'b000100,
        ST_PRECHARGE = 6'b001000,
        ST_REENABLE  = 6'b010000,
        ST_RESUME    = 6'b100000
    } hand_state_e;

    typedef struct packed {
        logic ack_n;
        logic addr_en;
        logic ctl_en;
        logic strobe_hi;
        logic resume;
    } drive_t;

    localparam hand_state_e RESET_STATE = ST_PRECHARGE;

    function automatic drive_t decode_drive(hand_state_e s);
        drive_t d;
        d = '{ack_n: 1'b1, addr_en: 1'b0, ctl_en: 1'b0, strobe_hi: 1'b0, resume: 1'b0};
        case (s)
            ST_OWNED:    begin d.addr_en = 1'b1; d.ctl_en = 1'b1; end
            ST_RELEASED: d.ack_n = 1'b0;
            ST_REENABLE: begin d.ctl_en = 1'b1; d.strobe_hi = 1'b1; end
            ST_RESUME:   begin d.addr_en = 1'b1; d.ctl_en = 1'b1; d.resume = 1'b1; end
            default:     ;
        endcase
        return d;
    endfunction

    function automatic logic owns_bus(hand_state_e s);
        return s == ST_OWNED;
    endfunction

endpackage

// File: rtl/bho_req_sync.sv
module bho_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    output logic req_act
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(negedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= req_n;
            end
        end else begin : g_multi
            always_ff @(negedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[LAST-1:0], req_n};
            end
        end
    endgenerate

    assign req_act = ~chain[LAST];
endmodule

// File: rtl/bho_fsm.sv
module bho_fsm
    import bho_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_act,
    input  logic        standby,
    input  logic        cycle_busy,
    output hand_state_e state
);
    hand_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_OWNED:     if (req_act && !standby && !cycle_busy) nxt = ST_RELEASING;
            ST_RELEASING: nxt = ST_RELEASED;
            ST_RELEASED:  if (!req_act) nxt = ST_PRECHARGE;
            ST_PRECHARGE: nxt = ST_REENABLE;
            ST_REENABLE:  nxt = ST_RESUME;
            ST_RESUME:    nxt = ST_OWNED;
            default:      nxt = RESET_STATE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= RESET_STATE;
        else     state <= nxt;
    end
endmodule

// File: rtl/bho_fall_stage.sv
module bho_fall_stage
    import bho_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  hand_state_e state,
    output logic        ext_en
);
    always_ff @(negedge clk) begin
        if (rst)                        ext_en <= 1'b0;
        else if (state == ST_RELEASING) ext_en <= 1'b1;
        else if (state == ST_REENABLE)  ext_en <= 1'b0;
    end
endmodule

// File: rtl/bho_out_stage.sv
module bho_out_stage
    import bho_pkg::*;
(
    input  hand_state_e state,
    input  logic        standby,
    input  logic        sleep_req,
    input  logic        mreset_req,
    output logic        ack_n,
    output logic        ack_oe,
    output logic        addr_en,
    output logic        ctl_en,
    output logic        strobe_hi,
    output logic        resume,
    output logic        sleep_go,
    output logic        mreset_go
);
    drive_t drv;
    logic   owned;

    always_comb begin
        drv       = decode_drive(state);
        owned     = owns_bus(state);
        ack_n     = drv.ack_n;
        addr_en   = drv.addr_en;
        ctl_en    = drv.ctl_en;
        strobe_hi = drv.strobe_hi;
        resume    = drv.resume;
        ack_oe    = ~standby;
        sleep_go  = sleep_req & owned;
        mreset_go = mreset_req & owned;
    end
endmodule

// File: rtl/bus_handoff_ctrl.sv
module bus_handoff_ctrl
    import bho_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    input  logic standby,
    input  logic cycle_busy,
    input  logic sleep_req,
    input  logic mreset_req,
    output logic ack_n,
    output logic ack_oe,
    output logic addr_en,
    output logic ctl_en,
    output logic strobe_hi,
    output logic ext_en,
    output logic resume,
    output logic sleep_go,
    output logic mreset_go
);
    logic        req_act;
    hand_state_e state;

    bho_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .req_n   (req_n),
        .req_act (req_act)
    );

    bho_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_act    (req_act),
        .standby    (standby),
        .cycle_busy (cycle_busy),
        .state      (state)
    );

    bho_fall_stage u_fall (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .ext_en (ext_en)
    );

    bho_out_stage u_out (
        .state      (state),
        .standby    (standby),
        .sleep_req  (sleep_req),
        .mreset_req (mreset_req),
        .ack_n      (ack_n),
        .ack_oe     (ack_oe),
        .addr_en    (addr_en),
        .ctl_en     (ctl_en),
        .strobe_hi  (strobe_hi),
        .resume     (resume),
        .sleep_go   (sleep_go),
        .mreset_go  (mreset_go)
    );
endmodule

// File: rtl/bus_handoff_ctrl_chk.sv
module bus_handoff_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic standby,
    input logic ack_n,
    input logic addr_en,
    input logic ctl_en,
    input logic strobe_hi,
    input logic ext_en,
    input logic resume,
    input logic sleep_go,
    input logic mreset_go
);
    AST_ACK_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> (!addr_en && !ctl_en)); // R3

    AST_ACK_BUFFER_ON: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> ext_en); // R3

    AST_PRECHARGE_FROM_OFF: assert property (@(posedge clk) disable iff (rst)
        strobe_hi |-> (!$past(addr_en) && !$past(ctl_en))); // R5

    AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (rst)
        resume |=> !resume); // R7

    AST_RESUME_FOLLOWS_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
        resume |-> $past(strobe_hi)); // R7

    AST_SLEEP_OWNED: assert property (@(posedge clk) disable iff (rst)
        sleep_go |-> (addr_en && ack_n && !resume)); // R8

    AST_MRESET_OWNED: assert property (@(posedge clk) disable iff (rst)
        mreset_go |-> (addr_en && ack_n && !resume)); // R8

    AST_STANDBY_KEEPS_BUS: assert property (@(posedge clk) disable iff (rst)
        (standby && addr_en) |=> addr_en); // R9
endmodule

bind bus_handoff_ctrl bus_handoff_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .standby   (standby),
    .ack_n     (ack_n),
    .addr_en   (addr_en),
    .ctl_en    (ctl_en),
    .strobe_hi (strobe_hi),
    .ext_en    (ext_en),
    .resume    (resume),
    .sleep_go  (sleep_go),
    .mreset_go (mreset_go)
);

// File: tb/bus_handoff_ctrl_tb.sv
module bus_handoff_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 41;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_n = 1'b1, standby = 1'b0, cycle_busy = 1'b0;
    logic sleep_req = 1'b0, mreset_req = 1'b0;
    logic ack_n, ack_oe, addr_en, ctl_en, strobe_hi, ext_en, resume, sleep_go, mreset_go;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_handoff_ctrl u_dut (
        .clk(clk), .rst(rst), .req_n(req_n), .standby(standby),
        .cycle_busy(cycle_busy), .sleep_req(sleep_req), .mreset_req(mreset_req),
        .ack_n(ack_n), .ack_oe(ack_oe), .addr_en(addr_en), .ctl_en(ctl_en),
        .strobe_hi(strobe_hi), .ext_en(ext_en), .resume(resume),
        .sleep_go(sleep_go), .mreset_go(mreset_go)
    );

    // row: {req number, {req_n,standby,cycle_busy,sleep_req,mreset_req},
    //       {ack_n,ack_oe,addr_en,ctl_en,strobe_hi,ext_en,resume,sleep_go,mreset_go}}
    localparam logic [17:0] VEC [NROWS] = '{
        {4'd1,  5'b10000, 9'b111100000},  // R1 owned after reset
        {4'd8,  5'b10010, 9'b111100010},  // R8 sleep granted
        {4'd8,  5'b10001, 9'b111100001},  // R8 reset granted
        {4'd2,  5'b00000, 9'b111100000},  // R2 sync stage 1
        {4'd2,  5'b00000, 9'b111100000},  // R2 sync stage 2
        {4'd2,  5'b00000, 9'b110001000},  // R2 drivers off, ack high
        {4'd8,  5'b00011, 9'b010001000},  // R8 held off while released
        {4'd3,  5'b00000, 9'b010001000},  // R3
        {4'd5,  5'b10000, 9'b010001000},  // R5 withdraw
        {4'd5,  5'b10000, 9'b010001000},  // R5
        {4'd5,  5'b10000, 9'b110001000},  // R5 ack high
        {4'd6,  5'b10000, 9'b110110000},  // R6 precharge, buffer off
        {4'd7,  5'b10010, 9'b111100100},  // R7 resume, sleep held
        {4'd8,  5'b10010, 9'b111100010},  // R8
        {4'd4,  5'b00100, 9'b111100000},  // R4 busy
        {4'd4,  5'b00100, 9'b111100000},  // R4
        {4'd4,  5'b00100, 9'b111100000},  // R4
        {4'd4,  5'b00000, 9'b111100000},  // R4
        {4'd4,  5'b00000, 9'b110001000},  // R4 release after busy
        {4'd3,  5'b00000, 9'b010001000},  // R3
        {4'd5,  5'b10000, 9'b010001000},  // R5
        {4'd5,  5'b10000, 9'b010001000},  // R5
        {4'd5,  5'b10000, 9'b110001000},  // R5
        {4'd6,  5'b10000, 9'b110110000},  // R6
        {4'd7,  5'b10000, 9'b111100100},  // R7
        {4'd7,  5'b10000, 9'b111100000},  // R7
        {4'd10, 5'b00000, 9'b111100000},  // R10 one-cycle pulse
        {4'd10, 5'b10000, 9'b111100000},  // R10
        {4'd10, 5'b10000, 9'b110001000},  // R10
        {4'd10, 5'b10000, 9'b010001000},  // R10 single ack cycle
        {4'd10, 5'b10000, 9'b110001000},  // R10
        {4'd10, 5'b10000, 9'b110110000},  // R10
        {4'd10, 5'b10000, 9'b111100100},  // R10
        {4'd10, 5'b10000, 9'b111100000},  // R10
        {4'd9,  5'b11000, 9'b101100000},  // R9 ack released
        {4'd9,  5'b01000, 9'b101100000},  // R9 request ignored
        {4'd9,  5'b01000, 9'b101100000},  // R9
        {4'd9,  5'b01000, 9'b101100000},  // R9
        {4'd9,  5'b11000, 9'b101100000},  // R9
        {4'd9,  5'b10000, 9'b111100000},  // R9
        {4'd9,  5'b10000, 9'b111100000}   // R9
    };

    function automatic logic [8:0] outs();
        return {ack_n, ack_oe, addr_en, ctl_en, strobe_hi, ext_en, resume, sleep_go, mreset_go};
    endfunction

    task automatic chk_vec(input int rq, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d at %0t: actual=%b expected=%b", rq, $time, act, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: during reset
        repeat (3) @(posedge clk);
        #3;
        chk_vec(1, outs(), 9'b110000000);
        @(posedge clk); #2 rst = 1'b0;
        #6 chk_vec(1, outs(), 9'b110000000);   // R1 precharge state
        @(posedge clk); #8 chk_vec(1, outs(), 9'b110110000); // R1
        @(posedge clk); #8 chk_vec(1, outs(), 9'b111100100); // R1 resume
        @(posedge clk); #8 chk_vec(1, outs(), 9'b111100000); // R1 owned

        for (int i = 0; i < NROWS; i++) begin
            @(posedge clk);
            #2 {req_n, standby, cycle_busy, sleep_req, mreset_req} = VEC[i][13:9];
            #6 chk_vec(int'(VEC[i][17:14]), outs(), VEC[i][8:0]);
        end

        // R6: half-cycle ordering of precharge and buffer disable
        @(posedge clk); #2 req_n = 1'b0;
        repeat (3) @(posedge clk);
        #8 chk_bit("R3", ack_n, 1'b0);
        @(posedge clk); #2 req_n = 1'b1;
        repeat (3) @(posedge clk);
        #3 chk_bit("R5", strobe_hi, 1'b1);
        chk_bit("R6", ext_en, 1'b1);
        #5 chk_bit("R6", ext_en, 1'b0);
        repeat (3) @(posedge clk);
        #8 chk_bit("R7", addr_en, 1'b1);

        // R1: reset while released
        @(posedge clk); #2 req_n = 1'b0;
        repeat (3) @(posedge clk);
        #8 chk_bit("R3", ack_n, 1'b0);
        @(posedge clk); #2 rst = 1'b1; req_n = 1'b1;
        @(posedge clk); #3 chk_bit("R1", ack_n, 1'b1);
        chk_bit("R1", addr_en, 1'b0);
        #3 chk_bit("R1", ext_en, 1'b0);
        @(posedge clk); #2 rst = 1'b0;
        repeat (2) @(posedge clk);
        #8 chk_bit("R1", resume, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule